// File: doc/BRIEF.md
# Vectored Interrupt Priority Arbiter

This block is the acceptance stage for up to 256 interrupt vectors. It records incoming requests in a request array and a trigger-mode array. It decides whether the processor should be interrupted, and it hands the processor the winning vector when the processor acknowledges. That vector then moves into an in-service array, and a software end-of-interrupt write retires it.

Priority is ordered by vector number, and the top four bits of a vector form its priority class. Software programs a task priority. The block combines that task priority with the class of the highest in-service vector to form the processor priority. A request only raises the interrupt line when its class beats the processor priority. An acknowledge that the task priority blocks returns a programmable spurious vector and changes no state.

Software reaches the block through a register port. The port is indexed by a word index taken from address bits 11:4, has a one-cycle read latency and takes single-cycle write strobes.

Top module: `irq_accept_unit`

## Requirements
- R1: When an acknowledge is taken, the vector chosen is the highest-numbered set bit of the request array. An empty array has no candidate.
- R2: The processor priority output equals the task priority when the task priority's class (bits 7:4) is at least the class of the highest in-service vector. Otherwise it equals that in-service class shifted left by four. An empty in-service array counts as class 0.
- R3: `irq_o` is high only when the enable bit (bit 8) of the spurious register is set and the request array is not empty. In addition, either the processor priority is zero or the class of the highest request is strictly greater than the processor priority's class.
- R4: An acknowledge that is taken clears the chosen bit in the request array, sets it in the in-service array and places the vector on `ack_vec_o` one cycle later. The spurious register's low byte is returned instead, with all arrays left unchanged, in three cases: the enable bit is clear, the request array is empty, or the task priority is nonzero and the candidate is less than or equal to it as an 8-bit number.
- R5: A request sets the request bit of its vector. It sets the trigger-mode bit when `req_level_i` is 1 (level) and clears it when `req_level_i` is 0 (edge).
- R6: A write to index 0x0B clears the highest set in-service bit. It acts on the in-service array held at the start of the cycle, and it does nothing when that array is empty.
- R7: Register map by index, with read data on `rd_data_o` in the cycle after `rd_en_i`:
  - 0x08: task priority, 8 bits, read/write.
  - 0x0A: processor priority, read-only.
  - 0x0F: spurious register, 9 bits, read/write.
  - 0x10–0x17: in-service array.
  - 0x18–0x1F: trigger-mode array.
  - 0x20–0x27: request array.
  - 0x28: error status.
  In each array window, word n holds vectors 32n to 32n+31, and bit i of the word is vector 32n+i. Writes to 0x0A, to the array windows and to 0x28 are ignored.
- R8: A read or write to any other index sets bit 7 of the error status, which stays set until reset. A read of index 0x0B also sets it, since that index is write-only.
- R9: After reset:
  - the spurious register reads 0x0FF, so the block is disabled;
  - the task priority and all three arrays are zero;
  - `ack_vec_o` and `rd_data_o` are zero.
- R10: A request and an acknowledge in the same cycle are applied request first, so a newly arriving higher vector is the one acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Request strobe |
| req_vec_i | input | 8 | Requested vector |
| req_level_i | input | 1 | Trigger mode of the request, 1 = level |
| ack_i | input | 1 | Processor acknowledge strobe |
| ack_vec_o | output | 8 | Vector returned by the last acknowledge |
| irq_o | output | 1 | Interrupt pending to the processor |
| ppr_o | output | 8 | Processor priority |
| reg_idx_i | input | 8 | Register word index (address bits 11:4) |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 9 | Low bits of the write word |
| rd_en_i | input | 1 | Register read strobe |
| rd_data_o | output | 32 | Read data, one cycle after the strobe |

## Verification
The bench targets cases where a plausible design goes wrong:
- Task priority blocking uses a full 8-bit compare, while the interrupt line uses a class compare. A design that mixed the two would either return a real vector where the spurious byte is due, or raise the line on an equal class.
- In a same-cycle request and acknowledge, a design that ignored the fresh request would hand out the older, lower vector.
- An end-of-interrupt that picked the lowest in-service bit would leave the processor priority stuck at the wrong class.
- An acknowledge of an empty or disabled block must return the spurious byte rather than a stale vector.

Random traffic then mixes all of these against the reference model on every cycle.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
   localparam int VEC_W   = 8;
   localparam int CLASS_W = 4;
   localparam int WORD_W  = 32;
   localparam int SPUR_W  = 9;

   typedef logic [VEC_W-1:0]   vec_t;
   typedef logic [CLASS_W-1:0] cls_t;

   localparam logic [7:0] IDX_TPR  = 8'h08;
   localparam logic [7:0] IDX_PPR  = 8'h0A;
   localparam logic [7:0] IDX_EOI  = 8'h0B;
   localparam logic [7:0] IDX_SPUR = 8'h0F;
   localparam logic [7:0] IDX_ERR  = 8'h28;
   localparam logic [4:0] WIN_ISR  = 5'b00010;
   localparam logic [4:0] WIN_TMR  = 5'b00011;
   localparam logic [4:0] WIN_IRR  = 5'b00100;
   localparam int         ERR_BIT  = 7;

   function automatic cls_t class_of(input vec_t v);
      return v[VEC_W-1 -: CLASS_W];
   endfunction
endpackage

// File: rtl/vec_msb_find.sv
module vec_msb_find #(
   parameter int WIDTH = 256,
   parameter int MODE  = 1,
   localparam int IDX_W = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] vec_i,
   output logic             found_o,
   output logic [IDX_W-1:0] idx_o
);
   localparam int GRP   = (WIDTH < 16) ? WIDTH : 16;
   localparam int NGRP  = WIDTH / GRP;
   localparam int GI_W  = $clog2(GRP);

   if (MODE != 0 && MODE != 1) begin : g_bad_mode
      $error("vec_msb_find: MODE must be 0 or 1");
   end
   if (WIDTH % GRP != 0) begin : g_bad_width
      $error("vec_msb_find: WIDTH must be a multiple of the group size");
   end

   if (MODE == 0) begin : g_flat
      always_comb begin
         found_o = 1'b0;
         idx_o   = '0;
         for (int i = 0; i < WIDTH; i++) begin
            if (vec_i[i]) begin
               found_o = 1'b1;
               idx_o   = IDX_W'(i);
            end
         end
      end
   end else begin : g_grouped
      logic [NGRP-1:0]           g_any;
      logic [NGRP-1:0][GI_W-1:0] g_idx;
      for (genvar g = 0; g < NGRP; g++) begin : g_grp
         logic [GI_W-1:0] loc;
         always_comb begin
            loc = '0;
            for (int j = 0; j < GRP; j++) begin
               if (vec_i[g*GRP + j]) loc = GI_W'(j);
            end
         end
         assign g_any[g] = |vec_i[g*GRP +: GRP];
         assign g_idx[g] = loc;
      end
      always_comb begin
         found_o = 1'b0;
         idx_o   = '0;
         for (int g = 0; g < NGRP; g++) begin
            if (g_any[g]) begin
               found_o = 1'b1;
               idx_o   = IDX_W'(g * GRP) | IDX_W'(g_idx[g]);
            end
         end
      end
   end
endmodule

// File: rtl/irq_prio_calc.sv
module irq_prio_calc
   import irq_arb_pkg::*;
(
   input  vec_t tpr_i,
   input  logic isr_found_i,
   input  cls_t isr_cls_i,
   input  logic irr_found_i,
   input  cls_t irr_cls_i,
   input  logic en_i,
   output vec_t ppr_o,
   output logic pend_o
);
   cls_t tpr_cls, svc_cls;

   assign tpr_cls = class_of(tpr_i);
   assign svc_cls = isr_found_i ? isr_cls_i : '0;

   always_comb begin
      if (tpr_cls >= svc_cls) ppr_o = tpr_i;
      else                    ppr_o = {svc_cls, {(VEC_W-CLASS_W){1'b0}}};
   end

   assign pend_o = en_i && irr_found_i &&
                   ((ppr_o == '0) || (irr_cls_i > class_of(ppr_o)));
endmodule

// File: rtl/irq_accept_unit.sv
module irq_accept_unit
   import irq_arb_pkg::*;
#(
   parameter int NUM_VEC   = 256,
   parameter int FIND_MODE = 1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req_valid_i,
   input  logic [7:0]  req_vec_i,
   input  logic        req_level_i,
   input  logic        ack_i,
   output logic [7:0]  ack_vec_o,
   output logic        irq_o,
   output logic [7:0]  ppr_o,
   input  logic [7:0]  reg_idx_i,
   input  logic        wr_en_i,
   input  logic [8:0]  wr_data_i,
   input  logic        rd_en_i,
   output logic [31:0] rd_data_o
);
   localparam int IDX_W  = $clog2(NUM_VEC);
   localparam int NWORDS = NUM_VEC / WORD_W;

   if (NUM_VEC < WORD_W || NUM_VEC > 256 || (1 << IDX_W) != NUM_VEC) begin : g_bad_num
      $error("irq_accept_unit: NUM_VEC must be a power of two from 32 to 256");
   end

   typedef logic [NUM_VEC-1:0] arr_t;

   arr_t                irr_q, isr_q, tmr_q;
   vec_t                tpr_q;
   logic [SPUR_W-1:0]   spur_q;
   logic                err_q;
   vec_t                ack_vec_q;
   logic [WORD_W-1:0]   rd_q;

   // request folded in before acknowledge selection (R10)
   logic req_ok;
   arr_t req_bit, irr_m;
   assign req_ok  = req_valid_i && ({1'b0, req_vec_i} < 9'(NUM_VEC));
   assign req_bit = req_ok ? (arr_t'(1) << req_vec_i) : '0;
   assign irr_m   = irr_q | req_bit;

   logic             irr_found, isr_found, ack_found;
   logic [IDX_W-1:0] irr_top, isr_top, ack_top;

   vec_msb_find #(.WIDTH(NUM_VEC), .MODE(FIND_MODE)) u_find_irr (
      .vec_i(irr_q), .found_o(irr_found), .idx_o(irr_top));
   vec_msb_find #(.WIDTH(NUM_VEC), .MODE(FIND_MODE)) u_find_isr (
      .vec_i(isr_q), .found_o(isr_found), .idx_o(isr_top));
   vec_msb_find #(.WIDTH(NUM_VEC), .MODE(FIND_MODE)) u_find_ack (
      .vec_i(irr_m), .found_o(ack_found), .idx_o(ack_top));

   vec_t irr_top_v, isr_top_v, ack_top_v;
   assign irr_top_v = VEC_W'(irr_top);
   assign isr_top_v = VEC_W'(isr_top);
   assign ack_top_v = VEC_W'(ack_top);

   logic pend;
   vec_t ppr;
   irq_prio_calc u_prio (
      .tpr_i      (tpr_q),
      .isr_found_i(isr_found),
      .isr_cls_i  (class_of(isr_top_v)),
      .irr_found_i(irr_found),
      .irr_cls_i  (class_of(irr_top_v)),
      .en_i       (spur_q[8]),
      .ppr_o      (ppr),
      .pend_o     (pend)
   );

   // acknowledge decision
   logic ack_blocked, ack_take;
   assign ack_blocked = (tpr_q != '0) && (ack_top_v <= tpr_q);
   assign ack_take    = ack_i && spur_q[8] && ack_found && !ack_blocked;

   // register decode
   logic [4:0] win;
   logic [2:0] word_sel;
   logic       in_arr_win, known_any, wr_ok, rd_ok, eoi;
   assign win        = reg_idx_i[7:3];
   assign word_sel   = reg_idx_i[2:0];
   assign in_arr_win = (win == WIN_ISR) || (win == WIN_TMR) || (win == WIN_IRR);
   assign known_any  = in_arr_win || (reg_idx_i == IDX_TPR) || (reg_idx_i == IDX_PPR) ||
                       (reg_idx_i == IDX_SPUR) || (reg_idx_i == IDX_ERR);
   assign wr_ok      = known_any || (reg_idx_i == IDX_EOI);
   assign rd_ok      = known_any;
   assign eoi        = wr_en_i && (reg_idx_i == IDX_EOI);

   function automatic logic [WORD_W-1:0] word_of(input arr_t a, input logic [2:0] w);
      logic [WORD_W-1:0] r;
      r = '0;
      for (int k = 0; k < NWORDS; k++) begin
         if (w == 3'(k)) r = a[k*WORD_W +: WORD_W];
      end
      return r;
   endfunction

   logic [WORD_W-1:0] rd_val;
   always_comb begin
      rd_val = '0;
      if      (reg_idx_i == IDX_TPR)  rd_val = WORD_W'(tpr_q);
      else if (reg_idx_i == IDX_PPR)  rd_val = WORD_W'(ppr);
      else if (reg_idx_i == IDX_SPUR) rd_val = WORD_W'(spur_q);
      else if (reg_idx_i == IDX_ERR)  rd_val = WORD_W'({err_q, {ERR_BIT{1'b0}}});
      else if (win == WIN_ISR)        rd_val = word_of(isr_q, word_sel);
      else if (win == WIN_TMR)        rd_val = word_of(tmr_q, word_sel);
      else if (win == WIN_IRR)        rd_val = word_of(irr_q, word_sel);
   end

   // next state
   arr_t ack_bit, eoi_clr;
   assign ack_bit = ack_take ? (arr_t'(1) << ack_top) : '0;
   assign eoi_clr = (eoi && isr_found) ? (arr_t'(1) << isr_top) : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irr_q     <= '0;
         isr_q     <= '0;
         tmr_q     <= '0;
         tpr_q     <= '0;
         spur_q    <= SPUR_W'(9'h0FF);
         err_q     <= 1'b0;
         ack_vec_q <= '0;
         rd_q      <= '0;
      end else begin
         irr_q <= irr_m & ~ack_bit;
         isr_q <= (isr_q & ~eoi_clr) | ack_bit;
         tmr_q <= (tmr_q & ~req_bit) | (req_level_i ? req_bit : '0);
         if (ack_i)   ack_vec_q <= ack_take ? ack_top_v : spur_q[7:0];
         if (rd_en_i) rd_q <= rd_val;
         if ((rd_en_i && !rd_ok) || (wr_en_i && !wr_ok)) err_q <= 1'b1;
         if (wr_en_i && reg_idx_i == IDX_TPR)  tpr_q  <= wr_data_i[7:0];
         if (wr_en_i && reg_idx_i == IDX_SPUR) spur_q <= wr_data_i;
      end
   end

   assign ack_vec_o = ack_vec_q;
   assign irq_o     = pend;
   assign ppr_o     = ppr;
   assign rd_data_o = rd_q;

   // ---------------- assertions ----------------
   assert_pend_top_R1: assert property (@(posedge clk) disable iff (!rst_n)
      irr_found |-> irr_q[irr_top]);

   assert_ack_highest_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && spur_q[8] && tpr_q == '0 && irr_m != '0)
      |=> ((irr_q >> ack_vec_o) == '0) && isr_q[ack_vec_o[IDX_W-1:0]]);

   assert_ppr_floor_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ppr_o >= tpr_q);

   assert_quiet_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !spur_q[8] |-> !irq_o);

   assert_spur_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && !spur_q[8]) |=> (ack_vec_o == $past(spur_q[7:0])));

   assert_req_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
      req_ok |=> (irr_q[$past(req_vec_i[IDX_W-1:0])] || isr_q[$past(req_vec_i[IDX_W-1:0])]));

   assert_tmr_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
      req_ok |=> (tmr_q[$past(req_vec_i[IDX_W-1:0])] == $past(req_level_i)));

   assert_eoi_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi && !ack_i && isr_q != '0) |=> ($countones(isr_q) == $past($countones(isr_q)) - 1));

   assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |=> err_q);
endmodule

// File: tb/irq_accept_unit_bench.sv
module irq_accept_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [7:0]  req_vec = '0;
   logic        req_level = 1'b0;
   logic        ack = 1'b0;
   logic [7:0]  reg_idx = '0;
   logic        wr_en = 1'b0;
   logic [8:0]  wr_data = '0;
   logic        rd_en = 1'b0;
   logic [7:0]  ack_vec;
   logic        irq;
   logic [7:0]  ppr;
   logic [31:0] rd_data;

   always #10 clk = ~clk;

   irq_accept_unit u_irq_accept_unit (
      .clk(clk), .rst_n(rst_n),
      .req_valid_i(req_valid), .req_vec_i(req_vec), .req_level_i(req_level),
      .ack_i(ack), .ack_vec_o(ack_vec), .irq_o(irq), .ppr_o(ppr),
      .reg_idx_i(reg_idx), .wr_en_i(wr_en), .wr_data_i(wr_data),
      .rd_en_i(rd_en), .rd_data_o(rd_data)
   );

   // reference model state
   logic [255:0] m_irr, m_isr, m_tmr;
   int           m_tpr, m_spur, m_ack, m_rd;
   bit           m_err;
   int           n_checks = 0, n_fail = 0;
   bit           done = 0;
   string        tag_irq = "R3", tag_ppr = "R2", tag_ack = "R4", tag_rd = "R7";

   function automatic int top_of(input logic [255:0] v);
      for (int i = 255; i >= 0; i--) if (v[i]) return i;
      return -1;
   endfunction

   function automatic int exp_ppr();
      int iv = top_of(m_isr);
      if (iv < 0) iv = 0;
      if ((m_tpr >> 4) >= (iv >> 4)) return m_tpr;
      return (iv >> 4) << 4;
   endfunction

   function automatic bit exp_irq();
      int t = top_of(m_irr);
      int p = exp_ppr();
      if (m_spur[8] == 0 || t < 0) return 0;
      return (p == 0) || ((t >> 4) > (p >> 4));
   endfunction

   function automatic bit idx_known(input int i);
      return i == 8'h08 || i == 8'h0A || i == 8'h0F || i == 8'h28 || (i >= 8'h10 && i <= 8'h27);
   endfunction

   function automatic int read_val(input int i);
      if (i == 8'h08) return m_tpr;
      if (i == 8'h0A) return exp_ppr();
      if (i == 8'h0F) return m_spur;
      if (i == 8'h28) return m_err ? 32'h80 : 0;
      if (i >= 8'h10 && i <= 8'h17) return int'(m_isr[(i-8'h10)*32 +: 32]);
      if (i >= 8'h18 && i <= 8'h1F) return int'(m_tmr[(i-8'h18)*32 +: 32]);
      if (i >= 8'h20 && i <= 8'h27) return int'(m_irr[(i-8'h20)*32 +: 32]);
      return 0;
   endfunction

   task automatic model_reset();
      m_irr = '0; m_isr = '0; m_tmr = '0;
      m_tpr = 0; m_spur = 'h0FF; m_ack = 0; m_rd = 0; m_err = 0;
   endtask

   task automatic model_step();
      logic [255:0] irr_m;
      int t, e, i;
      i = int'(reg_idx);
      if (rd_en) m_rd = read_val(i);
      if ((rd_en && !idx_known(i)) || (wr_en && !idx_known(i) && i != 8'h0B)) m_err = 1;
      irr_m = m_irr;
      if (req_valid) begin
         irr_m[req_vec] = 1'b1;
         m_tmr[req_vec] = req_level;
      end
      e = top_of(m_isr);
      if (wr_en && i == 8'h0B && e >= 0) m_isr[e] = 1'b0;
      if (ack) begin
         t = top_of(irr_m);
         if (m_spur[8] && t >= 0 && !(m_tpr != 0 && t <= m_tpr)) begin
            irr_m[t] = 1'b0;
            m_isr[t] = 1'b1;
            m_ack = t;
         end else m_ack = m_spur & 'hFF;
      end
      m_irr = irr_m;
      if (wr_en && i == 8'h08) m_tpr = int'(wr_data[7:0]);
      if (wr_en && i == 8'h0F) m_spur = int'(wr_data);
   endtask

   task automatic check(input string tag, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic compare_all();
      check(tag_irq, "irq", int'(irq), int'(exp_irq()));
      check(tag_ppr, "ppr", int'(ppr), exp_ppr());
      check(tag_ack, "ack_vec", int'(ack_vec), m_ack);
      check(tag_rd, "rd_data", int'(rd_data), m_rd);
   endtask

   task automatic cyc();
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare_all();
      req_valid = 0; ack = 0; wr_en = 0; rd_en = 0;
   endtask

   task automatic wr(input int i, input int d);
      reg_idx = 8'(i); wr_data = 9'(d); wr_en = 1; cyc();
   endtask

   task automatic rd(input int i, input string tag);
      tag_rd = tag; reg_idx = 8'(i); rd_en = 1; cyc();
   endtask

   task automatic req(input int v, input bit lvl);
      req_vec = 8'(v); req_level = lvl; req_valid = 1; cyc();
   endtask

   task automatic do_ack(input string tag);
      tag_ack = tag; ack = 1; cyc();
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual running expected finished");
      finish_run();
   end

   initial begin
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      // R9: reset state
      tag_irq = "R9"; tag_ppr = "R9"; tag_ack = "R9";
      compare_all();
      rd(8'h0F, "R9"); rd(8'h08, "R9"); rd(8'h20, "R9"); rd(8'h17, "R9");
      tag_irq = "R3"; tag_ppr = "R2";
      // disabled: request does not raise irq, ack gives spurious (R3, R4)
      req(8'h33, 0);
      do_ack("R4");
      wr(8'h0F, 'h1F0);
      // R5: requests and trigger modes
      req(8'h35, 0); req(8'h92, 1); req(8'h40, 1);
      rd(8'h21, "R5"); rd(8'h1C, "R5"); rd(8'h1A, "R5"); rd(8'h24, "R5");
      // R1: highest vector acknowledged, ppr follows service class
      do_ack("R1");
      rd(8'h14, "R1"); rd(8'h0A, "R2");
      // R4: task priority blocks by full-vector compare
      wr(8'h08, 'hA0);
      wr(8'h0B, 0);
      do_ack("R4");
      rd(8'h22, "R4");
      wr(8'h08, 'h41); do_ack("R4");
      wr(8'h08, 'h40); do_ack("R4");
      wr(8'h08, 'h3F); do_ack("R1");
      // R10: same-cycle request wins
      wr(8'h08, 0);
      req_vec = 8'hC8; req_level = 0; req_valid = 1; tag_ack = "R10"; ack = 1; cyc();
      rd(8'h16, "R10");
      // R6: EOI retires highest in-service only
      do_ack("R1");
      tag_ppr = "R6"; wr(8'h0B, 0); rd(8'h12, "R6"); rd(8'h16, "R6");
      wr(8'h0B, 0); wr(8'h0B, 0); wr(8'h0B, 0); rd(8'h11, "R6");
      tag_ppr = "R2";
      // boundary vectors 0 and 255
      req(8'hFF, 1); req(8'h00, 0); rd(8'h27, "R5"); rd(8'h20, "R5");
      do_ack("R1"); do_ack("R1"); do_ack("R1"); do_ack("R4");
      wr(8'h0B, 0); wr(8'h0B, 0); wr(8'h0B, 0);
      // R7: read-only regions ignore writes
      req(8'h41, 0);
      wr(8'h20, 'h1FF); wr(8'h0A, 'h1FF); wr(8'h18, 'h1FF); wr(8'h28, 'h1FF);
      rd(8'h22, "R7"); rd(8'h0A, "R7"); rd(8'h18, "R7"); rd(8'h28, "R7");
      // R8: unknown index sets error bit, sticky
      rd(8'h05, "R8"); rd(8'h28, "R8");
      wr(8'h3F, 'h1); rd(8'h0B, "R8"); rd(8'h28, "R8");
      // R3: class compare for the interrupt line
      wr(8'h08, 'h4F); rd(8'h08, "R3");
      req(8'h4F, 0); req(8'h50, 0); wr(8'h08, 'h5F);
      // R3/R4: disable via spurious enable bit
      wr(8'h0F, 'h0AB); rd(8'h0F, "R7"); do_ack("R4");
      wr(8'h0F, 'h1E3); wr(8'h08, 0);
      // random traffic against the model
      tag_ack = "R4"; tag_rd = "R7";
      for (int n = 0; n < 3000; n++) begin
         int r;
         if ($urandom_range(0, 9) < 3) begin
            req_valid = 1; req_vec = 8'($urandom_range(0, 255)); req_level = 1'($urandom_range(0, 1));
         end
         ack = ($urandom_range(0, 9) < 2);
         r = $urandom_range(0, 19);
         if (r == 0)      begin wr_en = 1; reg_idx = 8'h08; wr_data = 9'($urandom_range(0, 255)); end
         else if (r < 4)  begin wr_en = 1; reg_idx = 8'h0B; end
         else if (r == 4) begin wr_en = 1; reg_idx = 8'h0F; wr_data = 9'($urandom_range(0, 511) | (($urandom_range(0, 7) != 0) ? 256 : 0)); end
         else if (r < 9)  begin rd_en = 1; reg_idx = 8'($urandom_range(0, 63)); end
         cyc();
      end
      finish_run();
   end
endmodule